// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Timer

This block is a single up-counting timer that drives four pulse-width-modulated channels. A processor sets it up over a small synchronous register bus with a 4-bit address and 16-bit data. A divider sets the counting rate. A limit register sets the period. One compare register per channel sets the width of the active phase.

Each channel has a primary output and a complementary output. Each output has its own enable and its own polarity. A global output gate forces every output to its idle level.

The limit value and each compare value can be buffered. When a value is buffered, a write only reaches the working copy at an update event. An update event is either a natural wrap of the counter or a software-forced event. A software-forced event also restarts the divider and the counter.

Register map (all fields at bit 0 upward):

| Addr | Contents |
|------|----------|
| 0 | Control: bit0 `run`, bit1 `lim_buf` (buffer the limit), bit2 `gate` (global output enable) |
| 1 | Divider value D |
| 2 | Limit value L |
| 3 | Event: writing 1 to bit0 forces an update; reads 0 |
| 4..7 | Compare value C for channels 0..3 |
| 8..11 | Channel setup: bit0 `out_en`, bit1 `out_low`, bit2 `cmp_en`, bit3 `cmp_low`, bit4 `cmp_buf` (buffer the compare) |
| 12 | Current count, read-only |
| others | Read 0 |

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads 0, the count is 0, and both output vectors are 0.
- R2: While `run` is 1, the count advances once every D+1 clocks; for example, D=0 advances it on every clock.
- R3: When the count has reached L and the divider completes, the count returns to 0, so one period lasts L+1 counts. That return is an update event.
- R4: The reference of channel i is active exactly while count < C_i. C=0 therefore never activates it, and C>L keeps it active for the whole period.
- R5: With `cmp_buf` set, a written compare value is only used from the next update event on. With `cmp_buf` clear, it is used from the clock edge of the write.
- R6: With `lim_buf` set, a written limit is only used from the next update event on. With `lim_buf` clear, it is used at once.
- R7: Writing 1 to the event register clears the count and the divider and loads every buffered value, whether or not `run` is set. Writing 0 there does nothing.
- R8: When `out_en` is set and `gate` is set, the primary output is the reference XOR `out_low`.
- R9: When `cmp_en` is set and `gate` is set, the complementary output is the inverted reference XOR `cmp_low`.
- R10: When `gate` is clear, or an output's enable is clear, that output sits at its idle level: `out_low` for the primary output and `cmp_low` for the complementary output.
- R11: While `run` is 0, the count and the divider hold their values. Counting resumes from the held value when `run` is set again.
- R12: Each writable register reads back the value written to it. The limit and compare registers read back their written value, not their working copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pwm_o | output | 4 | Primary channel outputs |
| pwm_n_o | output | 4 | Complementary channel outputs |

## Verification
The properties assume that `wr_en`, `addr` and `wdata` are known and steady around each rising edge. They also assume that a force event lasts for exactly the cycles in which the event register is written with bit0 set. The bench changes inputs only on falling edges and never drives X. It issues each event write as a single-cycle strobe and goes back to idle reads of the count register between writes. The bench also counts on the hold and stability properties treating a same-cycle force as an exception. For that reason it places forced events both in running and in stopped phases.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIV   = 4'd1;
    localparam logic [ADDR_W-1:0] A_LIMIT = 4'd2;
    localparam logic [ADDR_W-1:0] A_EVENT = 4'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd12;

    // control word, run at bit 0
    typedef struct packed {
        logic gate;
        logic lim_buf;
        logic run;
    } ctrl_t;

    // per-channel setup, out_en at bit 0
    typedef struct packed {
        logic cmp_buf;
        logic cmp_low;
        logic cmp_en;
        logic out_low;
        logic out_en;
    } ch_cfg_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int CFG_W  = $bits(ch_cfg_t);

    function automatic logic is_cmp_addr(logic [ADDR_W-1:0] a);
        return a[3:2] == 2'b01;
    endfunction

    function automatic logic is_cfg_addr(logic [ADDR_W-1:0] a);
        return a[3:2] == 2'b10;
    endfunction

    // level of one pin: idle level when disabled, else reference with polarity
    function automatic logic pin_level(logic en, logic active, logic low);
        return en ? (active ^ low) : low;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DW-1:0]              wdata,
    input  logic                       upd_evt,
    input  logic [DW-1:0]              cnt,
    output logic [DW-1:0]              rdata,
    output ctrl_t                      ctrl,
    output logic [DW-1:0]              div,
    output logic [DW-1:0]              lim_act,
    output logic [NUM_CH-1:0][DW-1:0]  cmp_act,
    output ch_cfg_t [NUM_CH-1:0]       cfg,
    output logic                       force_evt
);

    logic [DW-1:0]             lim_wr;
    logic [NUM_CH-1:0][DW-1:0] cmp_wr;

    assign force_evt = wr_en && (addr == A_EVENT) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            div     <= '0;
            lim_wr  <= '0;
            lim_act <= '0;
            cmp_wr  <= '0;
            cmp_act <= '0;
            cfg     <= '0;
        end else begin
            // update event moves buffered values into working copies
            if (upd_evt) begin
                lim_act <= lim_wr;
                cmp_act <= cmp_wr;
            end
            if (wr_en) begin
                if (addr == A_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
                if (addr == A_DIV)  div  <= wdata;
                if (addr == A_LIMIT) begin
                    lim_wr <= wdata;
                    if (!ctrl.lim_buf) lim_act <= wdata;
                end
                for (int i = 0; i < NUM_CH; i++) begin
                    if (is_cmp_addr(addr) && addr[1:0] == 2'(i)) begin
                        cmp_wr[i] <= wdata;
                        if (!cfg[i].cmp_buf) cmp_act[i] <= wdata;
                    end
                    if (is_cfg_addr(addr) && addr[1:0] == 2'(i))
                        cfg[i] <= ch_cfg_t'(wdata[CFG_W-1:0]);
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)       rdata[CTRL_W-1:0] = ctrl;
        else if (addr == A_DIV)   rdata = div;
        else if (addr == A_LIMIT) rdata = lim_wr;
        else if (addr == A_COUNT) rdata = cnt;
        else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (is_cmp_addr(addr) && addr[1:0] == 2'(i)) rdata = cmp_wr[i];
                if (is_cfg_addr(addr) && addr[1:0] == 2'(i)) rdata[CFG_W-1:0] = cfg[i];
            end
        end
    end

endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    input  logic [DW-1:0] lim,
    input  logic          force_evt,
    output logic [DW-1:0] cnt,
    output logic          tick,
    output logic          upd_evt
);

    logic [DW-1:0] pre_q;
    logic          wrap;

    assign tick    = run && (pre_q >= div);
    // >= keeps a count above a freshly lowered limit from running to full scale
    assign wrap    = tick && (cnt >= lim);
    assign upd_evt = force_evt || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (force_evt) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (run) begin
            if (tick) begin
                pre_q <= '0;
                cnt   <= wrap ? '0 : cnt + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out
    import pwm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] cmp,
    input  ch_cfg_t       cfg,
    input  logic          gate,
    output logic          pin_p,
    output logic          pin_n
);

    logic ref_act;

    assign ref_act = cnt < cmp;
    assign pin_p   = pin_level(gate && cfg.out_en, ref_act, cfg.out_low);
    assign pin_n   = pin_level(gate && cfg.cmp_en, !ref_act, cfg.cmp_low);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NUM_CH-1:0] pwm_o,
    output logic [NUM_CH-1:0] pwm_n_o
);

    ctrl_t                      ctrl;
    ch_cfg_t [NUM_CH-1:0]       cfg;
    logic [DW-1:0]              div;
    logic [DW-1:0]              lim_act;
    logic [NUM_CH-1:0][DW-1:0]  cmp_act;
    logic [DW-1:0]              cnt;
    logic                       tick;
    logic                       upd_evt;
    logic                       force_evt;
    logic                       run;
    logic                       gate;
    logic [NUM_CH-1:0]          pol_vec;
    logic [NUM_CH-1:0]          cpol_vec;

    assign run  = ctrl.run;
    assign gate = ctrl.gate;

    pwm_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .upd_evt   (upd_evt),
        .cnt       (cnt),
        .rdata     (rdata),
        .ctrl      (ctrl),
        .div       (div),
        .lim_act   (lim_act),
        .cmp_act   (cmp_act),
        .cfg       (cfg),
        .force_evt (force_evt)
    );

    pwm_count #(.DW(DW)) u_count (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .div       (div),
        .lim       (lim_act),
        .force_evt (force_evt),
        .cnt       (cnt),
        .tick      (tick),
        .upd_evt   (upd_evt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_chan_out #(.DW(DW)) u_out (
            .cnt   (cnt),
            .cmp   (cmp_act[g]),
            .cfg   (cfg[g]),
            .gate  (gate),
            .pin_p (pwm_o[g]),
            .pin_n (pwm_n_o[g])
        );
        assign pol_vec[g]  = cfg[g].out_low;
        assign cpol_vec[g] = cfg[g].cmp_low;
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [3:0]        addr,
    input logic [DW-1:0]     wdata,
    input logic [NUM_CH-1:0] pwm_o,
    input logic [NUM_CH-1:0] pwm_n_o,
    input logic [DW-1:0]     cnt,
    input logic              tick,
    input logic              upd_evt,
    input logic              force_evt,
    input logic              run,
    input logic              gate,
    input logic [DW-1:0]     lim_act,
    input logic [NUM_CH-1:0] pol_vec,
    input logic [NUM_CH-1:0] cpol_vec
);

    AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_EVENT && wdata[0]) |=> (cnt == '0)); // R7

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !force_evt) |=> $stable(cnt)); // R11

    AST_PRESCALE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !force_evt) |=> $stable(cnt)); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt >= lim_act && !force_evt) |=> (cnt == '0)); // R3

    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!upd_evt && !(wr_en && addr == A_LIMIT)) |=> $stable(lim_act)); // R6

    AST_GATE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !gate |-> (pwm_o == pol_vec && pwm_n_o == cpol_vec)); // R10

endmodule

bind pwm_timer pwm_timer_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .pwm_o     (pwm_o),
    .pwm_n_o   (pwm_n_o),
    .cnt       (cnt),
    .tick      (tick),
    .upd_evt   (upd_evt),
    .force_evt (force_evt),
    .run       (run),
    .gate      (gate),
    .lim_act   (lim_act),
    .pol_vec   (pol_vec),
    .cpol_vec  (cpol_vec)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;

    localparam int NCH = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [3:0]  addr = 4'd12;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  pwm_o, pwm_n_o;

    always #4 clk = ~clk;

    pwm_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
    );

    typedef struct packed {
        logic [3:0]  p;
        logic [3:0]  n;
        logic [15:0] rd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    // expected-behaviour state, per the requirements
    logic [2:0]  m_ctrl;
    logic [15:0] m_div, m_lw, m_la, m_pre, m_cnt;
    logic [15:0] m_cw[NCH];
    logic [15:0] m_ca[NCH];
    logic [4:0]  m_cfg[NCH];

    function automatic logic [15:0] m_read(logic [3:0] a);
        if (a == 0) return {13'd0, m_ctrl};
        if (a == 1) return m_div;
        if (a == 2) return m_lw;
        if (a == 12) return m_cnt;
        if (a[3:2] == 2'b01) return m_cw[a[1:0]];
        if (a[3:2] == 2'b10) return {11'd0, m_cfg[a[1:0]]};
        return 16'd0;
    endfunction

    task automatic m_reset();
        m_ctrl = 0; m_div = 0; m_lw = 0; m_la = 0; m_pre = 0; m_cnt = 0;
        for (int i = 0; i < NCH; i++) begin m_cw[i] = 0; m_ca[i] = 0; m_cfg[i] = 0; end
    endtask

    // one clock: drive at falling edge, advance expected state, queue result
    task automatic cyc(input logic w, input logic [3:0] a, input logic [15:0] d, input string req);
        logic frc, tck, wrp, upd, rf;
        logic [15:0] n_pre, n_cnt, n_la;
        logic [15:0] n_ca[NCH];
        exp_t e;
        wr_en = w; addr = a; wdata = d;
        frc = w && a == 3 && d[0];
        tck = m_ctrl[0] && m_pre >= m_div;
        wrp = tck && m_cnt >= m_la;
        upd = frc || wrp;
        n_pre = frc ? 16'd0 : (m_ctrl[0] ? (tck ? 16'd0 : m_pre + 1) : m_pre);
        n_cnt = frc ? 16'd0 : (tck ? (wrp ? 16'd0 : m_cnt + 1) : m_cnt);
        n_la  = upd ? m_lw : m_la;
        for (int i = 0; i < NCH; i++) n_ca[i] = upd ? m_cw[i] : m_ca[i];
        if (w && a == 2) begin m_lw = d; if (!m_ctrl[1]) n_la = d; end
        for (int i = 0; i < NCH; i++) begin
            if (w && a == 4'(4 + i)) begin m_cw[i] = d; if (!m_cfg[i][4]) n_ca[i] = d; end
        end
        for (int i = 0; i < NCH; i++) if (w && a == 4'(8 + i)) m_cfg[i] = d[4:0];
        if (w && a == 0) m_ctrl = d[2:0];
        if (w && a == 1) m_div = d;
        m_pre = n_pre; m_cnt = n_cnt; m_la = n_la;
        for (int i = 0; i < NCH; i++) m_ca[i] = n_ca[i];
        for (int i = 0; i < NCH; i++) begin
            rf = m_cnt < m_ca[i];
            e.p[i] = (m_ctrl[2] && m_cfg[i][0]) ? (rf ^ m_cfg[i][1]) : m_cfg[i][1];
            e.n[i] = (m_ctrl[2] && m_cfg[i][2]) ? (!rf ^ m_cfg[i][3]) : m_cfg[i][3];
        end
        e.rd = m_read(a);
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input string req);
        cyc(1'b1, a, d, req);
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) cyc(1'b0, 4'd12, 16'd0, req);
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        cyc(1'b0, a, 16'd0, req);
    endtask

    // monitor: compare after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (pwm_o !== e.p || pwm_n_o !== e.n || rdata !== e.rd) begin
                n_fail++;
                $display("FAIL %s: pwm=%b n=%b rdata=%0d, expected pwm=%b n=%b rdata=%0d",
                         t, pwm_o, pwm_n_o, rdata, e.p, e.n, e.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        idle(2, "R1");
        rd(4'd0, "R1"); rd(4'd2, "R1"); rd(4'd4, "R1"); rd(4'd8, "R1");
        // R12 readback while configuring
        wr(4'd1, 16'd2, "R12");
        wr(4'd2, 16'd9, "R12");
        wr(4'd4, 16'd4, "R12");
        wr(4'd5, 16'd0, "R4");
        wr(4'd6, 16'd15, "R4");
        wr(4'd7, 16'd9, "R4");
        wr(4'd8, 16'd1, "R8");
        wr(4'd9, 16'd1, "R8");
        wr(4'd10, 16'd1, "R8");
        wr(4'd11, 16'd3, "R8");
        wr(4'd0, 16'd5, "R2");
        wr(4'd3, 16'd1, "R7");
        idle(40, "R2 R3 R4 R8");
        // R9 complementary outputs
        wr(4'd8, 16'd5, "R9");
        wr(4'd9, 16'd12, "R9");
        idle(35, "R9");
        // R5 buffered compare
        wr(4'd8, 16'd17, "R5");
        wr(4'd4, 16'd7, "R5");
        idle(35, "R5");
        // R6 buffered limit
        wr(4'd0, 16'd7, "R6");
        wr(4'd2, 16'd4, "R6");
        idle(35, "R6");
        // R7 forced update mid-period, and a zero write
        idle(5, "R7");
        wr(4'd3, 16'd0, "R7");
        idle(3, "R7");
        wr(4'd3, 16'd1, "R7");
        idle(10, "R7");
        // R11 stop and resume
        wr(4'd0, 16'd6, "R11");
        idle(10, "R11");
        wr(4'd3, 16'd1, "R11");
        idle(4, "R11");
        wr(4'd0, 16'd7, "R11");
        idle(10, "R11");
        // R10 global gate off
        wr(4'd0, 16'd3, "R10");
        idle(10, "R10");
        wr(4'd8, 16'd15, "R10");
        idle(4, "R10");
        // R2 divider of zero, gate back on
        wr(4'd0, 16'd7, "R2");
        wr(4'd1, 16'd0, "R2");
        idle(14, "R2");
        wr_en = 0;
        @(posedge clk); #3;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule